// File: doc/BRIEF.md
# At-Speed Capture Clock Switch

This block chooses the clock that one clock domain receives during scan testing. While the scan chains shift, the domain runs on the slow external test clock. In stuck-at testing, the test clock also supplies the capture edges. In at-speed testing, the block instead waits for scan enable to fall. It then lets a short, fixed burst of on-chip functional clock pulses through, which serve as launch and capture edges. When no test mode is active, the functional clock reaches the domain through nothing except the final output multiplexer.

A trigger flop clocked by the rising functional edge holds back the burst, so that the falling scan enable has time to reach every scan flop. A chain of non-scan flops clocked by the falling edge then forms a pulse window. The window is the first stage ANDed with the inverse of the last stage. It opens for exactly `N` functional periods and stays shut until the next shift. The window changes only while the functional clock is low, so every pulse it passes is complete. A per-domain capture enable, typically from a scannable register, can suppress all capture pulses.

Top module: `atspeed_clk_switch`

## Requirements
- R1: While `shift_en` is 1, every rising edge of `clk_test` produces exactly one rising edge on `clk_out`, whatever the mode inputs are.
- R2: With `slow_mode` at 1, `cap_en` at 1 and `shift_en` at 0, `clk_out` follows `clk_test`.
- R3: With `cap_en` at 0 and either test mode active, `clk_out` shows no rising edge while `shift_en` is 0.
- R4: With `fast_mode` at 1 and `cap_en` at 1, each interval with `shift_en` low gives exactly `N` rising edges on `clk_out`, provided the interval lasts at least N+2 functional periods.
- R5: The first burst pulse rises on the second rising edge of `clk_func` after `shift_en` falls. The first such edge only loads the trigger.
- R6: Every burst pulse is a complete high phase of `clk_func`. Its high time equals half a functional period, with no runt pulse.
- R7: A rising `shift_en` re-arms the block, so that each later capture interval in fast mode again yields a full burst of `N` pulses.
- R8: With neither test mode active and `shift_en` at 0, `clk_out` follows `clk_func` edge for edge, whatever `cap_en` is.
- R9: While `rst_n` is 0, the trigger and window flops are held at 0, so no burst pulse appears even in fast mode with shift low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_func | input | 1 | On-chip functional clock |
| clk_test | input | 1 | External scan/test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Scan shift enable |
| cap_en | input | 1 | Capture enable for this domain |
| fast_mode | input | 1 | Static at-speed test mode |
| slow_mode | input | 1 | Static stuck-at test mode, never 1 together with fast_mode |
| clk_out | output | 1 | Clock delivered to the domain |

## Verification
The bench builds the switch with `N` = 3 rather than the default of 2. This shows that the burst length comes from the stage count and not from a hard-wired pair. It also gives a window long enough to test that the count is exact inside capture intervals of varying length. The clocks are timed so that the 250 MHz functional clock and a 24 ns test clock are both low when inputs change. Every edge counted on `clk_out` can therefore be traced to either the mode or the window.

// File: rtl/atsw_pkg.sv
package atsw_pkg;

  typedef enum logic [1:0] {
    SRC_TEST  = 2'd0,
    SRC_BURST = 2'd1,
    SRC_FUNC  = 2'd2,
    SRC_HOLD  = 2'd3
  } clk_src_e;

  // Window is open from the first stage setting until the last stage catches up.
  function automatic logic pulse_window(input logic first_stg, input logic last_stg);
    return first_stg & ~last_stg;
  endfunction

  function automatic clk_src_e pick_source(input logic shift, input logic fast,
                                           input logic slow, input logic cap);
    if (shift)     return SRC_TEST;
    if (slow)      return cap ? SRC_TEST : SRC_HOLD;
    if (fast)      return SRC_BURST;
    return SRC_FUNC;
  endfunction

endpackage

// File: rtl/atsw_trigger.sv
module atsw_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_mode,
  input  logic shift_en,
  output logic trig_q
);
  // Loads on a rising edge; one functional period of delay before the window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= fast_mode & ~shift_en;
  end
endmodule

// File: rtl/atsw_window.sv
module atsw_window #(
  parameter int N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trig,
  output logic win
);
  import atsw_pkg::*;
  localparam int STAGES = N + 1;

  logic [STAGES-1:0] stg;

  // Falling-edge chain: the window moves only while clk is low.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic d;
      if (g == 0) begin : g_head
        assign d = trig;
      end else begin : g_tail
        assign d = stg[g-1];
      end
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)   stg[g] <= 1'b0;
        else if (clr) stg[g] <= 1'b0;
        else          stg[g] <= d;
      end
    end
  endgenerate

  assign win = pulse_window(stg[0], stg[STAGES-1]);
endmodule

// File: rtl/atsw_gate.sv
module atsw_gate (
  input  logic clk_in,
  input  logic win,
  input  logic cap_en,
  output logic clk_gated
);
  logic open_q;
  assign open_q    = win & cap_en;
  assign clk_gated = clk_in & open_q;
endmodule

// File: rtl/atspeed_clk_switch.sv
module atspeed_clk_switch #(
  parameter int N = 2
) (
  input  logic clk_func,
  input  logic clk_test,
  input  logic rst_n,
  input  logic shift_en,
  input  logic cap_en,
  input  logic fast_mode,
  input  logic slow_mode,
  output logic clk_out
);
  import atsw_pkg::*;

  logic     trig_q;
  logic     burst_win;
  logic     burst_clk;
  clk_src_e src_sel;

  atsw_trigger u_trig (
    .clk       (clk_func),
    .rst_n     (rst_n),
    .fast_mode (fast_mode),
    .shift_en  (shift_en),
    .trig_q    (trig_q)
  );

  atsw_window #(.N(N)) u_win (
    .clk   (clk_func),
    .rst_n (rst_n),
    .clr   (shift_en),
    .trig  (trig_q),
    .win   (burst_win)
  );

  atsw_gate u_gate (
    .clk_in    (clk_func),
    .win       (burst_win),
    .cap_en    (cap_en),
    .clk_gated (burst_clk)
  );

  assign src_sel = pick_source(shift_en, fast_mode, slow_mode, cap_en);

  always_comb begin
    unique case (src_sel)
      SRC_TEST:  clk_out = clk_test;
      SRC_BURST: clk_out = burst_clk;
      SRC_FUNC:  clk_out = clk_func;
      default:   clk_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/atsw_checker.sv
module atsw_checker #(
  parameter int N = 2
) (
  input logic clk_func,
  input logic rst_n,
  input logic shift_en,
  input logic cap_en,
  input logic fast_mode,
  input logic slow_mode,
  input logic trig_q,
  input logic burst_win,
  input logic clk_out
);
  localparam int CW = $clog2(N + 2) + 1;
  logic [CW-1:0] open_cnt;

  always_ff @(posedge clk_func or negedge rst_n) begin
    if (!rst_n)         open_cnt <= '0;
    else if (burst_win) open_cnt <= open_cnt + 1'b1;
    else                open_cnt <= '0;
  end

  AST_WIN_MAX_LEN: assert property (@(posedge clk_func) disable iff (!rst_n)
    open_cnt <= CW'(N)); // R4

  AST_WIN_NEEDS_TRIG: assert property (@(posedge clk_func) disable iff (!rst_n)
    burst_win |-> trig_q); // R5

  AST_SHIFT_CLOSES_WIN: assert property (@(posedge clk_func) disable iff (!rst_n)
    shift_en |=> !burst_win); // R7

  AST_NO_CAP_NO_CLK: assert property (@(negedge clk_func) disable iff (!rst_n)
    (!shift_en && !cap_en && (fast_mode || slow_mode)) |-> !clk_out); // R3

  AST_MODES_EXCL: assert property (@(posedge clk_func) disable iff (!rst_n)
    !(fast_mode && slow_mode)); // R2
endmodule

bind atspeed_clk_switch atsw_checker #(.N(N)) u_chk (
  .clk_func  (clk_func),
  .rst_n     (rst_n),
  .shift_en  (shift_en),
  .cap_en    (cap_en),
  .fast_mode (fast_mode),
  .slow_mode (slow_mode),
  .trig_q    (trig_q),
  .burst_win (burst_win),
  .clk_out   (clk_out)
);

// File: tb/atspeed_clk_switch_tb.sv
`timescale 1ns/1ps
module atspeed_clk_switch_tb;
  localparam int NP   = 3;
  localparam int TSLT = 24;  // test clock period, ns

  logic clk_func = 1'b0, clk_test = 1'b0;
  logic rst_n = 1'b0, shift_en = 1'b0, cap_en = 1'b1;
  logic fast_mode = 1'b1, slow_mode = 1'b0;
  logic clk_out;

  int checks = 0, errors = 0;
  int rises = 0, bad_width = 0;
  longint first_t = -1, rise_t = 0;
  bit in_burst = 1'b0;

  always #2 clk_func = ~clk_func;
  always #12 clk_test = ~clk_test;

  atspeed_clk_switch #(.N(NP)) u_dut (
    .clk_func(clk_func), .clk_test(clk_test), .rst_n(rst_n),
    .shift_en(shift_en), .cap_en(cap_en), .fast_mode(fast_mode),
    .slow_mode(slow_mode), .clk_out(clk_out)
  );

  always @(posedge clk_out) begin
    rises = rises + 1;
    rise_t = $time;
    if (first_t < 0) first_t = $time;
  end
  always @(negedge clk_out) if (in_burst && ($time - rise_t) != 2) bad_width = bad_width + 1;

  function automatic int want_edges(bit fast, bit slow, bit cap, int slots);
    if (fast) return cap ? NP : 0;
    if (slow) return cap ? slots : 0;
    return slots * (TSLT / 4);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Every input change lands 1 ns past a slot start: both clocks low.
  task automatic pattern(bit fast, bit slow, bit cap, int sh, int cp, string tag);
    fast_mode = fast; slow_mode = slow; cap_en = cap;
    shift_en = 1'b1; rises = 0;
    #(TSLT * sh);
    check({"R1 shift ", tag}, rises, sh);
    shift_en = 1'b0; rises = 0; first_t = -1; bad_width = 0;
    in_burst = fast & cap;
    begin
      longint t0 = $time;
      #(TSLT * cp);
      in_burst = 1'b0;
      if (fast && cap) begin
        check({"R4 burst count ", tag}, rises, NP);
        check({"R5 first pulse ", tag}, first_t - t0, 5);
        check({"R6 pulse width ", tag}, bad_width, 0);
      end else if (!cap && (fast || slow)) begin
        check({"R3 capture off ", tag}, rises, 0);
      end else if (slow) begin
        check({"R2 slow capture ", tag}, rises, want_edges(fast, slow, cap, cp));
      end else begin
        check({"R8 functional ", tag}, rises, want_edges(fast, slow, cap, cp));
      end
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    rises = 0;
    #(TSLT * 2);
    check("R9 reset quiet", rises, 0);
    rst_n = 1'b1; shift_en = 1'b1;
    #(TSLT);
    // Directed corners
    pattern(1, 0, 1, 1, 2, "fast min");
    pattern(1, 0, 1, 1, 2, "R7 rearm");
    pattern(1, 0, 0, 2, 3, "fast nocap");
    pattern(0, 1, 1, 1, 3, "slow cap");
    pattern(0, 1, 0, 2, 2, "slow nocap");
    pattern(0, 0, 0, 1, 2, "func");
    pattern(1, 0, 1, 3, 4, "fast long");
    // Random mix
    for (int i = 0; i < 60; i++) begin
      int m = $urandom_range(2, 0);
      pattern(m == 0, m == 1, 1'($urandom_range(1, 0)),
              $urandom_range(3, 1), $urandom_range(4, 2), "rand");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule